// File: doc/BRIEF.md
# Coprocessor Shared-RAM Host Access Port

This block sits between a host register bus and the byte-wide working RAM of an attached coprocessor. The host never sees the RAM directly. It loads a 16-bit pointer through two byte registers, then moves bytes one at a time through a data window. An optional auto-advance mode steps the pointer after every window access, so code upload, download or compare is one pointer load followed by a run of window accesses.

One control/status byte serves several purposes:
- It starts and stops the coprocessor.
- It rings a one-cycle doorbell towards the coprocessor.
- It reports two event flags that the coprocessor raises for the host. Each flag is cleared by writing 1 to it.

The RAM has one port. The coprocessor's own memory bus shares it with the host window. When both want the RAM in the same cycle, the host wins.

The pointer is always 16 bits wide. The RAM depth is a parameter, and the RAM decodes only the low pointer bits, so a smaller RAM appears mirrored across the pointer space. A liveness check uses an ordinary RAM location and needs no special hardware: the coprocessor writes 0xFF there, and the host reads it through the window and writes 0 back.

Top module: `shram_host_port`

## Requirements
- R1: The host register select `h_addr` decodes 0 = pointer low byte, 1 = pointer high byte, 2 = data window, 3 = control/status. A write to 0 or 1 replaces that byte of the 16-bit pointer. A read of 0 or 1 returns that byte of the pointer.
- R2: A host read of the data window returns the RAM byte at the pointer on `h_rdata` in the cycle after the request. Every host register read has this one-cycle latency.
- R3: A host write of the data window stores `h_wdata` at the pointer.
- R4: With the auto-advance bit (control bit 2) set, each data-window access, read or write, adds one to the pointer. With the bit clear, the pointer does not move.
- R5: On auto-advance, the pointer wraps from 0xFFFF to 0x0000.
- R6: Control bit 1 is the run bit. `cp_run` follows the last value written to it and is 0 after reset.
- R7: A control write with bit 4 = 1 and bit 1 = 1 drives `cp_doorbell` high for exactly the following cycle. A control write with bit 4 set and bit 1 clear gives no pulse. Bit 4 reads back as 0.
- R8: A pulse on `cp_int0_set` or `cp_int1_set` sets flag 0 (status bit 5) or flag 1 (status bit 6) respectively. `host_irq` is high while either flag is set.
- R9: Writing 1 to a flag bit clears that flag. Writing 0 to it leaves the flag unchanged. A set and a clear of the same flag in the same cycle leave the flag set.
- R10: In a cycle with a host data-window access, `cp_gnt` is low and the coprocessor access is not performed. Otherwise a coprocessor request is granted at once. Granted reads return data on `cp_rdata` in the next cycle.
- R11: After synchronous reset, the pointer is 0, the control/status byte reads 0, and `host_irq`, `cp_run` and `cp_doorbell` are 0.
- R12: A byte written to a RAM location by the coprocessor is read by the host through the window, and a byte written by the host is read by the coprocessor. The liveness handshake (coprocessor writes 0xFF, host reads it and writes 0) is built from these accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host register access this cycle |
| h_wr | input | 1 | 1 = host write, 0 = host read |
| h_addr | input | 2 | Host register select |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte, valid the cycle after the read |
| host_irq | output | 1 | Either event flag is set |
| cp_run | output | 1 | Coprocessor released from stop |
| cp_doorbell | output | 1 | One-cycle interrupt to the coprocessor |
| cp_int0_set | input | 1 | Coprocessor raises flag 0 |
| cp_int1_set | input | 1 | Coprocessor raises flag 1 |
| cp_req | input | 1 | Coprocessor RAM request |
| cp_we | input | 1 | Coprocessor write enable |
| cp_addr | input | RAM_AW | Coprocessor RAM address |
| cp_wdata | input | 8 | Coprocessor write byte |
| cp_gnt | output | 1 | Coprocessor request taken this cycle |
| cp_rdata | output | 8 | Coprocessor read byte, valid the cycle after a granted read |

## Verification
The hardest cases to reach from the ports are the collisions. The first is a host window access and a coprocessor request landing in the same cycle. The second is a flag being raised by the coprocessor in the very cycle the host clears it. The stimulus drives both sides from one task on the same falling edge.

A collision where the coprocessor holds its request shows that the stalled write lands one cycle later and overwrites the host's byte. A collision where the coprocessor drops its request after one cycle shows that the refused access left its target location untouched. Pointer wrap is reached by loading 0xFFFF directly rather than by stepping.

// File: rtl/shram_pkg.sv
package shram_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [1:0] {
        REG_PTR_LO = 2'd0,
        REG_PTR_HI = 2'd1,
        REG_DATA   = 2'd2,
        REG_CTRL   = 2'd3
    } host_reg_e;

    localparam int BIT_RUN     = 1;
    localparam int BIT_AUTOINC = 2;
    localparam int BIT_IRQ     = 4;
    localparam int BIT_INT0    = 5;
    localparam int BIT_INT1    = 6;

    typedef struct packed {
        logic              valid;
        logic              wr;
        host_reg_e         sel;
        logic [BYTE_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic int1;
        logic int0;
        logic autoinc;
        logic run;
    } ctrl_state_t;

    function automatic logic [BYTE_W-1:0] pack_status(ctrl_state_t s);
        logic [BYTE_W-1:0] b;
        b              = '0;
        b[BIT_RUN]     = s.run;
        b[BIT_AUTOINC] = s.autoinc;
        b[BIT_INT0]    = s.int0;
        b[BIT_INT1]    = s.int1;
        return b;
    endfunction

endpackage

// File: rtl/shram_ptr.sv
module shram_ptr
    import shram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  host_req_t        req,
    input  logic             autoinc,
    output logic [PTR_W-1:0] ptr
);

    logic wr_lo, wr_hi, step;

    always_comb begin
        wr_lo = req.valid && req.wr && (req.sel == REG_PTR_LO);
        wr_hi = req.valid && req.wr && (req.sel == REG_PTR_HI);
        step  = req.valid && (req.sel == REG_DATA) && autoinc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (wr_lo) begin
            ptr[BYTE_W-1:0] <= req.wdata;
        end else if (wr_hi) begin
            ptr[PTR_W-1:BYTE_W] <= req.wdata;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.sel == REG_DATA && autoinc) |=> (ptr == $past(ptr) + 16'd1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!autoinc && !(req.valid && req.wr && (req.sel == REG_PTR_LO || req.sel == REG_PTR_HI)))
        |=> $stable(ptr));

endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
    import shram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic              int0_set,
    input  logic              int1_set,
    output ctrl_state_t       st,
    output logic              doorbell,
    output logic [BYTE_W-1:0] status
);

    logic wr_ctrl;
    logic clr0, clr1;

    always_comb begin
        wr_ctrl = req.valid && req.wr && (req.sel == REG_CTRL);
        clr0    = wr_ctrl && req.wdata[BIT_INT0];
        clr1    = wr_ctrl && req.wdata[BIT_INT1];
        status  = pack_status(st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            doorbell <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                st.run     <= req.wdata[BIT_RUN];
                st.autoinc <= req.wdata[BIT_AUTOINC];
            end
            st.int0  <= int0_set | (st.int0 & ~clr0);
            st.int1  <= int1_set | (st.int1 & ~clr1);
            doorbell <= wr_ctrl && req.wdata[BIT_IRQ] && req.wdata[BIT_RUN];
        end
    end

    assert_doorbell_cause_R7: assert property (@(posedge clk) disable iff (rst)
        doorbell |-> $past(req.valid && req.wr && req.sel == REG_CTRL && req.wdata[BIT_IRQ]));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        (int0_set || int1_set) |=> (st.int0 || st.int1));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr0 && !int0_set) |=> !st.int0);

    assert_flag_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (st.int1 && !clr1) |=> st.int1);

endmodule

// File: rtl/shram_mem.sv
module shram_mem
    import shram_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [RAM_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [RAM_AW-1:0] cp_addr,
    input  logic [BYTE_W-1:0] cp_wdata,
    output logic              cp_gnt,
    output logic [BYTE_W-1:0] host_q,
    output logic [BYTE_W-1:0] cp_q
);

    localparam int DEPTH = 1 << RAM_AW;

    logic [BYTE_W-1:0] ram [DEPTH];
    logic [RAM_AW-1:0] a;
    logic              we;
    logic [BYTE_W-1:0] wd;

    always_comb begin
        cp_gnt = cp_req && !host_en;
        a      = host_en ? host_addr  : cp_addr;
        we     = host_en ? host_we    : (cp_gnt && cp_we);
        wd     = host_en ? host_wdata : cp_wdata;
    end

    always_ff @(posedge clk) begin
        if (we) ram[a] <= wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_q <= '0;
            cp_q   <= '0;
        end else begin
            if (host_en && !host_we) host_q <= ram[a];
            if (cp_gnt && !cp_we)    cp_q   <= ram[a];
        end
    end

    assert_host_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (host_en && cp_req) |-> !cp_gnt);

    assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        cp_gnt |-> cp_req);

endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
    import shram_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic [1:0]        h_addr,
    input  logic [7:0]        h_wdata,
    output logic [7:0]        h_rdata,
    output logic              host_irq,
    output logic              cp_run,
    output logic              cp_doorbell,
    input  logic              cp_int0_set,
    input  logic              cp_int1_set,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [RAM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic              cp_gnt,
    output logic [7:0]        cp_rdata
);

    host_req_t         req;
    ctrl_state_t       st;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] status;
    logic [BYTE_W-1:0] mem_hq;
    logic              win;
    logic [BYTE_W-1:0] reg_val;
    host_reg_e         rd_sel_q;
    logic [BYTE_W-1:0] rd_val_q;

    always_comb begin
        req.valid = h_sel;
        req.wr    = h_wr;
        req.sel   = host_reg_e'(h_addr);
        req.wdata = h_wdata;
        win       = h_sel && (req.sel == REG_DATA);
        unique case (req.sel)
            REG_PTR_LO: reg_val = ptr[BYTE_W-1:0];
            REG_PTR_HI: reg_val = ptr[PTR_W-1:BYTE_W];
            REG_CTRL:   reg_val = status;
            default:    reg_val = '0;
        endcase
    end

    shram_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .autoinc (st.autoinc),
        .ptr     (ptr)
    );

    shram_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .int0_set (cp_int0_set),
        .int1_set (cp_int1_set),
        .st       (st),
        .doorbell (cp_doorbell),
        .status   (status)
    );

    shram_mem #(.RAM_AW(RAM_AW)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .host_en    (win),
        .host_we    (h_wr),
        .host_addr  (ptr[RAM_AW-1:0]),
        .host_wdata (h_wdata),
        .cp_req     (cp_req),
        .cp_we      (cp_we),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .cp_gnt     (cp_gnt),
        .host_q     (mem_hq),
        .cp_q       (cp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel_q <= REG_PTR_LO;
            rd_val_q <= '0;
        end else if (h_sel && !h_wr) begin
            rd_sel_q <= req.sel;
            rd_val_q <= reg_val;
        end
    end

    always_comb begin
        h_rdata  = (rd_sel_q == REG_DATA) ? mem_hq : rd_val_q;
        host_irq = st.int0 || st.int1;
        cp_run   = st.run;
    end

    assert_irq_follows_flags_R8: assert property (@(posedge clk) disable iff (rst)
        cp_int0_set |=> host_irq);

    assert_run_written_R6: assert property (@(posedge clk) disable iff (rst)
        (h_sel && h_wr && h_addr == 2'd3) |=> (cp_run == $past(h_wdata[1])));

endmodule

// File: tb/tb_shram_host_port.sv
module tb_shram_host_port;

    localparam int RAM_AW = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              h_sel = 1'b0, h_wr = 1'b0;
    logic [1:0]        h_addr = '0;
    logic [7:0]        h_wdata = '0;
    logic [7:0]        h_rdata;
    logic              host_irq, cp_run, cp_doorbell;
    logic              cp_int0_set = 1'b0, cp_int1_set = 1'b0;
    logic              cp_req = 1'b0, cp_we = 1'b0;
    logic [RAM_AW-1:0] cp_addr = '0;
    logic [7:0]        cp_wdata = '0;
    logic              cp_gnt;
    logic [7:0]        cp_rdata;

    int   n_total = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic iss;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got;

    always #5 clk = ~clk;

    shram_host_port #(.RAM_AW(RAM_AW)) dut (
        .clk(clk), .rst(rst), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
        .cp_run(cp_run), .cp_doorbell(cp_doorbell),
        .cp_int0_set(cp_int0_set), .cp_int1_set(cp_int1_set),
        .cp_req(cp_req), .cp_we(cp_we), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_gnt(cp_gnt), .cp_rdata(cp_rdata)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
    endtask

    task automatic hr(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
        @(negedge clk);
        h_sel = 1'b0;
    endtask

    task automatic set_ptr(logic [15:0] p);
        hw(2'd0, p[7:0]);
        hw(2'd1, p[15:8]);
    endtask

    task automatic cp_wr(logic [RAM_AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = a; cp_wdata = d;
        @(negedge clk);
        cp_req = 1'b0; cp_we = 1'b0;
    endtask

    task automatic cp_rd(logic [RAM_AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cp_req = 1'b1; cp_we = 1'b0; cp_addr = a;
        @(negedge clk);
        cp_req = 1'b0;
        d = cp_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // scoreboard monitor: pops one expected byte per host read
    always begin
        @(posedge clk);
        iss = h_sel && !h_wr && !rst;
        @(negedge clk);
        if (iss) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 16'd1, 16'd0);
            end else begin
                chk(tag_q.pop_front(), {8'h00, h_rdata}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_total++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11 cp_run", {15'd0, cp_run}, 16'd0);
        chk("R11 host_irq", {15'd0, host_irq}, 16'd0);
        chk("R11 doorbell", {15'd0, cp_doorbell}, 16'd0);
        hr(2'd3, 8'h00, "R11 status");
        hr(2'd0, 8'h00, "R11 ptr lo");

        // R1 pointer load and readback
        set_ptr(16'h1234);
        hr(2'd0, 8'h34, "R1 ptr lo");
        hr(2'd1, 8'h12, "R1 ptr hi");

        // R3/R4 writes with auto-advance
        hw(2'd3, 8'h04);
        hw(2'd2, 8'hA5); hw(2'd2, 8'h5A); hw(2'd2, 8'hC3);
        hr(2'd0, 8'h37, "R4 ptr after three writes");
        set_ptr(16'h1234);
        hr(2'd2, 8'hA5, "R2 read 0");
        hr(2'd2, 8'h5A, "R2 read 1");
        hr(2'd2, 8'hC3, "R3 read 2");
        hr(2'd0, 8'h37, "R4 ptr after three reads");

        // R4 auto-advance off
        hw(2'd3, 8'h00);
        set_ptr(16'h0010);
        hw(2'd2, 8'h11); hw(2'd2, 8'h22);
        hr(2'd0, 8'h10, "R4 ptr held");
        hr(2'd2, 8'h22, "R4 overwrite same byte");

        // R5 wrap
        hw(2'd3, 8'h04);
        set_ptr(16'hFFFF);
        hw(2'd2, 8'h77); hw(2'd2, 8'h88);
        hr(2'd0, 8'h01, "R5 wrap lo");
        hr(2'd1, 8'h00, "R5 wrap hi");
        set_ptr(16'hFFFF);
        hr(2'd2, 8'h77, "R5 byte at top");
        hr(2'd2, 8'h88, "R5 byte at zero");

        // R6 run bit
        hw(2'd3, 8'h06);
        chk("R6 run set", {15'd0, cp_run}, 16'd1);
        hr(2'd3, 8'h06, "R6 status");
        hw(2'd3, 8'h04);
        chk("R6 run clear", {15'd0, cp_run}, 16'd0);

        // R7 doorbell
        hw(2'd3, 8'h16);
        chk("R7 doorbell pulse", {15'd0, cp_doorbell}, 16'd1);
        @(negedge clk);
        chk("R7 doorbell one cycle", {15'd0, cp_doorbell}, 16'd0);
        hw(2'd3, 8'h14);
        chk("R7 no doorbell when stopped", {15'd0, cp_doorbell}, 16'd0);
        hr(2'd3, 8'h04, "R7 irq bit reads 0");

        // R8 flags
        @(negedge clk); cp_int0_set = 1'b1;
        @(negedge clk); cp_int0_set = 1'b0;
        chk("R8 host_irq", {15'd0, host_irq}, 16'd1);
        hr(2'd3, 8'h24, "R8 flag0");
        @(negedge clk); cp_int1_set = 1'b1;
        @(negedge clk); cp_int1_set = 1'b0;
        hr(2'd3, 8'h64, "R8 both flags");

        // R9 write-one-to-clear
        hw(2'd3, 8'h04);
        hr(2'd3, 8'h64, "R9 zero keeps flags");
        hw(2'd3, 8'h24);
        hr(2'd3, 8'h44, "R9 clear flag0");
        chk("R9 irq still high", {15'd0, host_irq}, 16'd1);
        hw(2'd3, 8'h44);
        hr(2'd3, 8'h04, "R9 clear flag1");
        chk("R9 irq low", {15'd0, host_irq}, 16'd0);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = 2'd3; h_wdata = 8'h24; cp_int0_set = 1'b1;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0; cp_int0_set = 1'b0;
        hr(2'd3, 8'h24, "R9 set wins over clear");
        hw(2'd3, 8'h24);

        // R10 collision, coprocessor retries
        set_ptr(16'h0100);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = 2'd2; h_wdata = 8'h99;
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = 10'h100; cp_wdata = 8'h55;
        #1 chk("R10 host wins", {15'd0, cp_gnt}, 16'd0);
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
        #1 chk("R10 granted after stall", {15'd0, cp_gnt}, 16'd1);
        @(negedge clk);
        cp_req = 1'b0; cp_we = 1'b0;
        set_ptr(16'h0100);
        hr(2'd2, 8'h55, "R10 stalled write lands later");

        // R10 collision, coprocessor withdraws
        cp_wr(10'h201, 8'h00);
        set_ptr(16'h0200);
        @(negedge clk);
        h_sel = 1'b1; h_wr = 1'b1; h_addr = 2'd2; h_wdata = 8'h11;
        cp_req = 1'b1; cp_we = 1'b1; cp_addr = 10'h201; cp_wdata = 8'hEE;
        #1 chk("R10 refused", {15'd0, cp_gnt}, 16'd0);
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0; cp_req = 1'b0; cp_we = 1'b0;
        set_ptr(16'h0200);
        hr(2'd2, 8'h11, "R10 host byte");
        hr(2'd2, 8'h00, "R10 refused write had no effect");

        // R12 liveness handshake
        hw(2'd3, 8'h00);
        cp_wr(10'h021, 8'hFF);
        set_ptr(16'h0021);
        hr(2'd2, 8'hFF, "R12 alive byte seen");
        hw(2'd2, 8'h00);
        cp_rd(10'h021, got);
        chk("R12 coprocessor sees cleared byte", {8'h00, got}, 16'h0000);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
        finish_run();
    end

endmodule